// File: doc/BRIEF.md
# DisplayPort Link Training Sequencer

This block brings a DisplayPort main link up after the sink has been detected. It takes the sink's capability values (protocol version, highest link rate code, lane count) and drives the whole training exchange through an abstract AUX request/response port. Each sink register access goes out as one request carrying an address, a length and write data. It stays pending until the AUX engine acknowledges it, and read data comes back with the acknowledge. The physical AUX signalling and the lane PHY are outside the block.

Training runs in this order. The link rate is written, then the lane count. Next comes a clock recovery phase on pattern 1 and a channel equalisation phase on pattern 2. In both phases the block works out the drive levels itself from the sink's adjust requests, and every lane gets the same levels. Waits are counted in pulses of a microsecond tick. Every attempt ends by switching the pattern off. A failed attempt at a higher rate is repeated once at the 1.62 Gb/s rate code. At the end a one-cycle done pulse is raised, together with a pass/fail level and the rate finally used.

Top module: `dp_link_trainer`

## Requirements
- R1: After start, the first write sets sink address 0x100 to the rate code. The second sets 0x101 to the lane count in bits 2:0, with bit 7 (enhanced framing) set only when the sink version is 0x11 or above.
- R2: Clock recovery writes 0x01 to the pattern register 0x102. It then commits drive bytes of zero as a 4-byte write to 0x103 (byte i belongs to lane i; inactive lanes get 0x00). After each commit it waits at least WAIT_CR_US ticks before reading 2 status bytes from 0x202.
- R3: Lane i's status nibble sits at bits i*4+3:i*4 of the status bytes read as a little-endian word. Bit 0 of the nibble means clock recovered. Only lanes below the configured lane count (1, 2 or 4) are considered.
- R4: If clock recovery is not complete on all active lanes and the current drive byte carries the swing-max flag (bit 2), the attempt fails without adjusting.
- R5: A try counter restarts whenever the swing field (bits 1:0) of the committed drive byte differs from the one seen at the previous status read. The attempt fails at the fifth status read with the same swing.
- R6: An adjustment reads 2 bytes from 0x206 (lane i's nibble at bits i*4+3:i*4; swing in nibble bits 1:0, pre-emphasis in 3:2). It takes the maximum of each over the active lanes. A value at or above MAX_SWING / MAX_PRE is clamped to that maximum with bit 2 of the 3-bit field set. The drive byte is (pre<<3)|swing.
- R7: Equalisation writes 0x02 to 0x102 and performs at most 6 reads of 3 status bytes, each after at least WAIT_EQ_US ticks. It passes only when byte 2 bit 0 (inter-lane align) is set and every active lane has nibble bits 0, 1 and 2 set. Otherwise it adjusts and commits before the next read.
- R8: If any active lane shows clock recovery lost during equalisation, the attempt fails at once.
- R9: Every attempt ends with a write of 0x00 to 0x102. The final one is followed by a single-cycle done pulse, with pass_o high only on success.
- R10: A failed attempt at a rate code other than 0x06 is restarted from the rate write at 0x06. link_rate_o reports the rate code in use.
- R11: A pending AUX request keeps its address, direction and data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin training (sampled when idle) |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| sink_ver_i | input | 8 | Sink protocol version |
| sink_rate_i | input | 8 | Initial link rate code |
| sink_lanes_i | input | 3 | Lane count (1, 2 or 4) |
| aux_req_o | output | 1 | AUX request pending |
| aux_wr_o | output | 1 | 1 = write, 0 = read |
| aux_addr_o | output | 20 | Sink register address |
| aux_len_o | output | 3 | Transfer length in bytes |
| aux_wdata_o | output | 32 | Write bytes, byte 0 in bits 7:0 |
| aux_ack_i | input | 1 | Request completed, read data valid |
| aux_rdata_i | input | 24 | Read bytes, byte 0 in bits 7:0 |
| lane_drive_o | output | 8 | Current per-lane drive byte |
| train_pat_o | output | 2 | Last training pattern written |
| link_rate_o | output | 8 | Rate code in use |
| busy_o | output | 1 | Training in progress |
| done_o | output | 1 | Training finished (one cycle) |
| pass_o | output | 1 | Result of the last training |

## Verification
The hardest path to reach is the rate fallback combined with the two clock recovery exits: the max-flag abort and the five-try limit at an unchanged swing. It takes a sink that fails only at the high rate and answers adjust requests whose swing is either zero or at the maximum. The bench's AUX responder model plays a sink with a scripted personality per run. That covers status that turns good after a given number of reads, a recovery loss on the first equalisation read, missing alignment, and failure tied to the current rate. Random personalities are mixed with directed ones that force each exit.

// File: rtl/dp_lt_pkg.sv
package dp_lt_pkg;
  localparam logic [19:0] ADDR_RATE    = 20'h00100;
  localparam logic [19:0] ADDR_LANES   = 20'h00101;
  localparam logic [19:0] ADDR_PATTERN = 20'h00102;
  localparam logic [19:0] ADDR_DRIVE   = 20'h00103;
  localparam logic [19:0] ADDR_STATUS  = 20'h00202;
  localparam logic [19:0] ADDR_ADJUST  = 20'h00206;
  localparam logic [7:0]  RATE_LOW     = 8'h06;
  localparam logic [7:0]  VER_EF       = 8'h11;
  localparam int          MAX_LINK     = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_RATE, S_LANES, S_PAT1, S_CR_COMMIT, S_CR_WAIT, S_CR_STAT,
    S_CR_ADJ, S_PAT2, S_EQ_WAIT, S_EQ_STAT, S_EQ_ADJ, S_EQ_COMMIT, S_PAT0,
    S_DONE
  } lt_state_e;
endpackage

// File: rtl/dp_lt_timer.sv
module dp_lt_timer #(
  parameter int CR_US = 100,
  parameter int EQ_US = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic sel_eq_i,
  input  logic tick_i,
  output logic zero_o
);
  localparam int MAXV = (CR_US > EQ_US) ? CR_US : EQ_US;
  localparam int W    = $clog2(MAXV + 1) + 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= sel_eq_i ? W'(EQ_US) : W'(CR_US);
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dp_lt_lane_eval.sv
module dp_lt_lane_eval #(
  parameter int LANES = 4
) (
  input  logic [23:0]      status_i,
  input  logic [LANES-1:0] active_i,
  output logic             cr_all_o,
  output logic             eq_all_o,
  output logic             cr_lost_o
);
  logic [LANES-1:0] cr_ok, full_ok;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [3:0] nib;
    assign nib        = status_i[i*4 +: 4];
    assign cr_ok[i]   = !active_i[i] || nib[0];
    assign full_ok[i] = !active_i[i] || (nib[2:0] == 3'b111);
  end

  assign cr_all_o  = &cr_ok;
  assign cr_lost_o = ~cr_all_o;
  assign eq_all_o  = (&full_ok) && status_i[16];
endmodule

// File: rtl/dp_lt_adjust.sv
module dp_lt_adjust #(
  parameter int LANES     = 4,
  parameter int MAX_SWING = 3,
  parameter int MAX_PRE   = 2
) (
  input  logic [15:0]      req_i,
  input  logic [LANES-1:0] active_i,
  output logic [7:0]       drive_o
);
  logic [2:0] vs, pe;

  always_comb begin
    vs = '0;
    pe = '0;
    for (int i = 0; i < LANES; i++) begin
      if (active_i[i]) begin
        if ({1'b0, req_i[i*4 +: 2]} > vs)     vs = {1'b0, req_i[i*4 +: 2]};
        if ({1'b0, req_i[i*4+2 +: 2]} > pe)   pe = {1'b0, req_i[i*4+2 +: 2]};
      end
    end
    if (vs >= 3'(MAX_SWING)) vs = 3'(MAX_SWING) | 3'b100;
    if (pe >= 3'(MAX_PRE))   pe = 3'(MAX_PRE) | 3'b100;
    drive_o = {2'b00, pe, vs};
  end
endmodule

// File: rtl/dp_link_trainer.sv
module dp_link_trainer
  import dp_lt_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int MAX_SWING  = 3,
  parameter int MAX_PRE    = 2,
  parameter int WAIT_CR_US = 100,
  parameter int WAIT_EQ_US = 400,
  parameter int CR_TRIES   = 5,
  parameter int EQ_TRIES   = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        us_tick_i,
  input  logic [7:0]  sink_ver_i,
  input  logic [7:0]  sink_rate_i,
  input  logic [2:0]  sink_lanes_i,
  output logic        aux_req_o,
  output logic        aux_wr_o,
  output logic [19:0] aux_addr_o,
  output logic [2:0]  aux_len_o,
  output logic [31:0] aux_wdata_o,
  input  logic        aux_ack_i,
  input  logic [23:0] aux_rdata_i,
  output logic [7:0]  lane_drive_o,
  output logic [1:0]  train_pat_o,
  output logic [7:0]  link_rate_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        pass_o
);
  localparam int TMAX  = (CR_TRIES > EQ_TRIES) ? CR_TRIES : EQ_TRIES;
  localparam int TRY_W = $clog2(TMAX + 1);

  lt_state_e        state_q;
  logic [7:0]       rate_q, drive_q;
  logic [2:0]       lanes_q;
  logic             ef_q, sw_valid_q, pass_q;
  logic [1:0]       last_sw_q, pat_q;
  logic [TRY_W-1:0] cr_try_q, eq_try_q, try_nxt;
  logic [MAX_LINK-1:0] act4;
  logic [31:0]      commit_word;
  logic             cr_all, eq_all, cr_lost, tmr_zero, tmr_load, tmr_eq, acc;
  logic [7:0]       adj_drive;

  for (genvar g = 0; g < MAX_LINK; g++) begin : g_act
    if (g < LANES) begin : g_on
      assign act4[g] = (lanes_q > 3'(g));
    end else begin : g_off
      assign act4[g] = 1'b0;
    end
    assign commit_word[g*8 +: 8] = act4[g] ? drive_q : 8'h00;
  end

  dp_lt_lane_eval #(.LANES(LANES)) i_eval (
    .status_i (aux_rdata_i),
    .active_i (act4[LANES-1:0]),
    .cr_all_o (cr_all),
    .eq_all_o (eq_all),
    .cr_lost_o(cr_lost)
  );

  dp_lt_adjust #(.LANES(LANES), .MAX_SWING(MAX_SWING), .MAX_PRE(MAX_PRE)) i_adj (
    .req_i   (aux_rdata_i[15:0]),
    .active_i(act4[LANES-1:0]),
    .drive_o (adj_drive)
  );

  dp_lt_timer #(.CR_US(WAIT_CR_US), .EQ_US(WAIT_EQ_US)) i_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tmr_load),
    .sel_eq_i(tmr_eq),
    .tick_i  (us_tick_i),
    .zero_o  (tmr_zero)
  );

  // AUX request decode
  always_comb begin
    aux_req_o   = 1'b1;
    aux_wr_o    = 1'b1;
    aux_addr_o  = ADDR_PATTERN;
    aux_len_o   = 3'd1;
    aux_wdata_o = '0;
    unique case (state_q)
      S_RATE:  begin aux_addr_o = ADDR_RATE; aux_wdata_o[7:0] = rate_q; end
      S_LANES: begin
        aux_addr_o = ADDR_LANES;
        aux_wdata_o[7:0] = {ef_q, 4'b0000, lanes_q};
      end
      S_PAT1:  aux_wdata_o[7:0] = 8'h01;
      S_PAT2:  aux_wdata_o[7:0] = 8'h02;
      S_PAT0:  aux_wdata_o[7:0] = 8'h00;
      S_CR_COMMIT, S_EQ_COMMIT: begin
        aux_addr_o = ADDR_DRIVE; aux_len_o = 3'd4; aux_wdata_o = commit_word;
      end
      S_CR_STAT: begin aux_wr_o = 1'b0; aux_addr_o = ADDR_STATUS; aux_len_o = 3'd2; end
      S_EQ_STAT: begin aux_wr_o = 1'b0; aux_addr_o = ADDR_STATUS; aux_len_o = 3'd3; end
      S_CR_ADJ, S_EQ_ADJ: begin
        aux_wr_o = 1'b0; aux_addr_o = ADDR_ADJUST; aux_len_o = 3'd2;
      end
      default: begin aux_req_o = 1'b0; aux_wr_o = 1'b0; end
    endcase
  end

  assign acc      = aux_req_o && aux_ack_i;
  assign tmr_load = acc && (state_q == S_CR_COMMIT || state_q == S_PAT2 ||
                            state_q == S_EQ_COMMIT);
  assign tmr_eq   = (state_q != S_CR_COMMIT);
  assign try_nxt  = (sw_valid_q && drive_q[1:0] == last_sw_q) ? cr_try_q + 1'b1
                                                               : TRY_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      rate_q     <= '0;
      lanes_q    <= '0;
      ef_q       <= 1'b0;
      drive_q    <= '0;
      last_sw_q  <= '0;
      sw_valid_q <= 1'b0;
      cr_try_q   <= '0;
      eq_try_q   <= '0;
      pass_q     <= 1'b0;
      pat_q      <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          rate_q  <= sink_rate_i;
          lanes_q <= sink_lanes_i;
          ef_q    <= (sink_ver_i >= VER_EF);
          pass_q  <= 1'b0;
          state_q <= S_RATE;
        end
        S_RATE:  if (acc) state_q <= S_LANES;
        S_LANES: if (acc) state_q <= S_PAT1;
        S_PAT1: if (acc) begin
          pat_q      <= 2'd1;
          drive_q    <= '0;
          sw_valid_q <= 1'b0;
          cr_try_q   <= '0;
          state_q    <= S_CR_COMMIT;
        end
        S_CR_COMMIT: if (acc) state_q <= S_CR_WAIT;
        S_CR_WAIT:   if (tmr_zero) state_q <= S_CR_STAT;
        S_CR_STAT: if (acc) begin
          last_sw_q  <= drive_q[1:0];
          sw_valid_q <= 1'b1;
          cr_try_q   <= try_nxt;
          if (cr_all)                                       state_q <= S_PAT2;
          else if (drive_q[2] || try_nxt == TRY_W'(CR_TRIES)) state_q <= S_PAT0;
          else                                              state_q <= S_CR_ADJ;
        end
        S_CR_ADJ: if (acc) begin
          drive_q <= adj_drive;
          state_q <= S_CR_COMMIT;
        end
        S_PAT2: if (acc) begin
          pat_q    <= 2'd2;
          eq_try_q <= '0;
          state_q  <= S_EQ_WAIT;
        end
        S_EQ_WAIT: if (tmr_zero) state_q <= S_EQ_STAT;
        S_EQ_STAT: if (acc) begin
          if (cr_lost) state_q <= S_PAT0;
          else if (eq_all) begin
            pass_q  <= 1'b1;
            state_q <= S_PAT0;
          end else if (eq_try_q == TRY_W'(EQ_TRIES - 1)) state_q <= S_PAT0;
          else state_q <= S_EQ_ADJ;
        end
        S_EQ_ADJ: if (acc) begin
          drive_q <= adj_drive;
          state_q <= S_EQ_COMMIT;
        end
        S_EQ_COMMIT: if (acc) begin
          eq_try_q <= eq_try_q + 1'b1;
          state_q  <= S_EQ_WAIT;
        end
        S_PAT0: if (acc) begin
          pat_q <= 2'd0;
          if (pass_q) state_q <= S_DONE;
          else if (rate_q != RATE_LOW) begin
            rate_q  <= RATE_LOW;
            state_q <= S_RATE;
          end else state_q <= S_DONE;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign lane_drive_o = drive_q;
  assign train_pat_o  = pat_q;
  assign link_rate_o  = rate_q;
  assign busy_o       = (state_q != S_IDLE) && (state_q != S_DONE);
  assign done_o       = (state_q == S_DONE);
  assign pass_o       = pass_q;
endmodule

// File: rtl/dp_link_trainer_chk.sv
module dp_link_trainer_chk
  import dp_lt_pkg::*;
#(
  parameter int MAX_SWING = 3,
  parameter int MAX_PRE   = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        aux_req_o,
  input logic        aux_wr_o,
  input logic [19:0] aux_addr_o,
  input logic [31:0] aux_wdata_o,
  input logic        aux_ack_i,
  input logic [7:0]  lane_drive_o,
  input logic [7:0]  link_rate_o,
  input logic        busy_o,
  input logic        done_o
);
  logic pat0_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pat0_seen <= 1'b0;
    else if (aux_req_o && aux_ack_i && aux_wr_o && aux_addr_o == ADDR_PATTERN)
      pat0_seen <= (aux_wdata_o[7:0] == 8'h00);
  end

  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_req_o && !aux_ack_i |=> aux_req_o && $stable(aux_addr_o) &&
                                $stable(aux_wr_o) && $stable(aux_wdata_o));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_pat0_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pat0_seen && !aux_req_o);

  a_r10_rate_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && link_rate_o != $past(link_rate_o)
      |-> link_rate_o == RATE_LOW);

  a_r6_swing_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_drive_o[2] |-> lane_drive_o[1:0] == 2'(MAX_SWING));

  a_r6_pre_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_drive_o[5] |-> lane_drive_o[4:3] == 2'(MAX_PRE));
endmodule

bind dp_link_trainer dp_link_trainer_chk #(.MAX_SWING(MAX_SWING), .MAX_PRE(MAX_PRE)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .aux_req_o   (aux_req_o),
  .aux_wr_o    (aux_wr_o),
  .aux_addr_o  (aux_addr_o),
  .aux_wdata_o (aux_wdata_o),
  .aux_ack_i   (aux_ack_i),
  .lane_drive_o(lane_drive_o),
  .link_rate_o (link_rate_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/test_dp_link_trainer.sv
module test_dp_link_trainer;
  localparam int MAXS = 3, MAXP = 2, WCR = 10, WEQ = 40;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tick = 1'b0;
  logic [7:0] ver = 0, rate = 0;
  logic [2:0] lanes = 0;
  logic aux_req, aux_wr, aux_ack = 1'b0, busy, done, pass;
  logic [19:0] aux_addr;
  logic [2:0] aux_len;
  logic [31:0] aux_wdata;
  logic [23:0] aux_rdata = 0;
  logic [7:0] drive, link_rate;
  logic [1:0] pat;

  int tests = 0, fails = 0, cyc = 0;

  // sink personality
  int s_lanes, s_cr_ok_at, s_eq_ok_at;
  bit s_cr_loss, s_fail_high, s_noalign;
  logic [7:0] s_req0, s_req1;

  // responder log
  int wr_n, cr_total, eq_total, cr_reads, eq_reads, gap_min, commit_cyc, mism;
  logic [19:0] wr0_addr, wr1_addr, st_addr;
  logic [7:0] wr0_data, wr1_data, last_pat, cur_rate;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  dp_link_trainer #(.MAX_SWING(MAXS), .MAX_PRE(MAXP), .WAIT_CR_US(WCR),
                    .WAIT_EQ_US(WEQ)) i_dp_link_trainer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .us_tick_i(tick),
    .sink_ver_i(ver), .sink_rate_i(rate), .sink_lanes_i(lanes),
    .aux_req_o(aux_req), .aux_wr_o(aux_wr), .aux_addr_o(aux_addr),
    .aux_len_o(aux_len), .aux_wdata_o(aux_wdata), .aux_ack_i(aux_ack),
    .aux_rdata_i(aux_rdata), .lane_drive_o(drive), .train_pat_o(pat),
    .link_rate_o(link_rate), .busy_o(busy), .done_o(done), .pass_o(pass));

  task automatic chk(string req, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pack(int l, logic [3:0] v, logic [3:0] lastv);
    logic [15:0] r = 0;
    for (int i = 0; i < 4; i++)
      if (i < l) r[i*4 +: 4] = (i == l - 1) ? lastv : v;
    return r;
  endfunction

  // R6 expected drive byte
  function automatic logic [7:0] adj_byte(int l, logic [7:0] r0, logic [7:0] r1);
    logic [15:0] rq = {r1, r0};
    int vs = 0, pe = 0;
    for (int i = 0; i < l; i++) begin
      if (int'(rq[i*4 +: 2]) > vs) vs = int'(rq[i*4 +: 2]);
      if (int'(rq[i*4+2 +: 2]) > pe) pe = int'(rq[i*4+2 +: 2]);
    end
    if (vs >= MAXS) vs = MAXS + 4;
    if (pe >= MAXP) pe = MAXP + 4;
    return 8'((pe << 3) | vs);
  endfunction

  task automatic serve();
    if (aux_wr) begin
      if (wr_n == 0) begin wr0_addr = aux_addr; wr0_data = aux_wdata[7:0]; end
      if (wr_n == 1) begin wr1_addr = aux_addr; wr1_data = aux_wdata[7:0]; end
      wr_n++;
      if (aux_addr == 20'h100) cur_rate = aux_wdata[7:0];
      if (aux_addr == 20'h102) begin
        last_pat = aux_wdata[7:0];
        if (last_pat == 8'h01) cr_reads = 0;
        if (last_pat == 8'h02) eq_reads = 0;
      end
      if (aux_addr == 20'h103) commit_cyc = cyc;
    end else if (aux_addr == 20'h206) begin
      aux_rdata = {8'h00, s_req1, s_req0};
    end else if (aux_len == 3'd2) begin
      cr_reads++; cr_total++;
      if (!(s_fail_high && cur_rate != 8'h06) && s_cr_ok_at != 0 && cr_reads >= s_cr_ok_at)
        aux_rdata = {8'h00, pack(s_lanes, 4'h1, 4'h1)};
      else
        aux_rdata = {8'h00, pack(s_lanes, 4'h1, 4'h0)};
    end else begin
      eq_reads++; eq_total++;
      if (s_cr_loss && eq_reads == 1) aux_rdata = {8'h01, pack(s_lanes, 4'h7, 4'h6)};
      else if (s_eq_ok_at != 0 && eq_reads >= s_eq_ok_at)
        aux_rdata = {8'h01, pack(s_lanes, 4'h7, 4'h7)};
      else if (s_noalign) aux_rdata = {8'h00, pack(s_lanes, 4'h7, 4'h7)};
      else aux_rdata = {8'h01, pack(s_lanes, 4'h1, 4'h1)};
    end
  endtask

  // AUX responder and tick source
  initial begin
    bit pend = 0;
    int wn = 0;
    forever begin
      @(negedge clk);
      tick = ~tick;
      if (aux_ack) aux_ack = 1'b0;
      else if (rst_n && aux_req) begin
        if (!pend) begin
          pend = 1; wn = int'($urandom % 3); st_addr = aux_addr;
          if (!aux_wr && aux_addr == 20'h202 && aux_len == 3'd2 && commit_cyc >= 0)
            if (cyc - commit_cyc < gap_min) gap_min = cyc - commit_cyc;
        end else if (aux_addr != st_addr) mism++;
        if (wn == 0) begin serve(); aux_ack = 1'b1; pend = 0; end
        else wn--;
      end
    end
  end

  task automatic predict(output bit p, output int crn, output int eqn,
                         output logic [7:0] rt, output logic [7:0] dr);
    logic [7:0] d, a;
    int last, tries;
    bit crok;
    a = adj_byte(s_lanes, s_req0, s_req1);
    rt = rate; crn = 0; eqn = 0; p = 0; dr = 0;
    for (int att = 0; att < 2; att++) begin
      d = 0; last = -1; tries = 0; crok = 0;
      for (int k = 1; k <= 20; k++) begin
        crn++;
        if (!(s_fail_high && rt != 8'h06) && s_cr_ok_at != 0 && k >= s_cr_ok_at) begin
          crok = 1; break;
        end
        if (int'(d[1:0]) != last) begin last = int'(d[1:0]); tries = 0; end
        tries++;
        if (d[2] || tries == 5) break;
        d = a;
      end
      if (crok)
        for (int j = 1; j <= 6; j++) begin
          eqn++;
          if (s_cr_loss && j == 1) break;
          if (s_eq_ok_at != 0 && j >= s_eq_ok_at) begin p = 1; break; end
          if (j == 6) break;
          d = a;
        end
      dr = d;
      if (p || rt == 8'h06) break;
      rt = 8'h06;
    end
  endtask

  task automatic run(string name);
    bit ep; int ecr, eeq; logic [7:0] ert, edr;
    predict(ep, ecr, eeq, ert, edr);
    wr_n = 0; cr_total = 0; eq_total = 0; gap_min = 1 << 20; commit_cyc = -1; mism = 0;
    @(negedge clk);
    ver = ver; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk("R1", int'(wr0_addr), 'h100, {name, " first write address"});
    chk("R1", int'(wr1_addr), 'h101, {name, " second write address"});
    chk("R1", int'(wr1_data), s_lanes | ((ver >= 8'h11) ? 'h80 : 0), {name, " lane count byte"});
    chk("R9", int'(pass), int'(ep), {name, " pass result"});
    chk("R9", int'(last_pat), 0, {name, " final pattern write"});
    chk("R10", int'(link_rate), int'(ert), {name, " final rate"});
    chk("R3", cr_total, ecr, {name, " clock recovery status reads"});
    chk("R7", eq_total, eeq, {name, " equalisation status reads"});
    chk("R6", int'(drive), int'(edr), {name, " drive byte"});
    chk("R2", int'(gap_min >= 2 * WCR - 2), 1, {name, " recovery wait length"});
    chk("R11", mism, 0, {name, " request address held"});
    @(negedge clk);
    chk("R9", int'(done), 0, {name, " done is a single pulse"});
  endtask

  task automatic setup(int l, logic [7:0] v, logic [7:0] r, logic [7:0] q0, logic [7:0] q1,
                       int cra, int eqa, bit loss, bit fh, bit na);
    lanes = 3'(l); s_lanes = l; ver = v; rate = r; s_req0 = q0; s_req1 = q1;
    s_cr_ok_at = cra; s_eq_ok_at = eqa; s_cr_loss = loss; s_fail_high = fh; s_noalign = na;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: done actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R9", int'(busy), 0, "reset busy");
    chk("R11", int'(aux_req), 0, "reset request");
    chk("R9", int'(done), 0, "reset done");
    rst_n = 1'b1;
    @(negedge clk);
    // directed corner cases
    setup(4, 8'h12, 8'h0A, 8'h00, 8'h00, 1, 1, 0, 0, 0); run("R1 immediate pass");
    setup(2, 8'h10, 8'h0A, 8'h21, 8'h00, 3, 2, 0, 0, 0); run("R1 no enhanced framing");
    setup(4, 8'h11, 8'h0A, 8'h12, 8'h31, 2, 3, 0, 1, 0); run("R10 fallback");
    setup(1, 8'h11, 8'h06, 8'hF0, 8'h00, 0, 1, 0, 0, 0); run("R5 same swing limit");
    setup(2, 8'h11, 8'h06, 8'h03, 8'h00, 0, 1, 0, 0, 0); run("R4 max flag abort");
    setup(4, 8'h11, 8'h0A, 8'h01, 8'h10, 2, 1, 1, 0, 0); run("R8 recovery lost");
    setup(4, 8'h11, 8'h06, 8'h05, 8'h00, 1, 0, 0, 0, 1); run("R7 align missing");
    setup(1, 8'h11, 8'h06, 8'h0B, 8'hFF, 2, 4, 0, 0, 0); run("R3 single lane");
    for (int n = 0; n < 30; n++) begin
      int lsel = int'($urandom % 3);
      setup((lsel == 0) ? 1 : (lsel == 1) ? 2 : 4, 8'($urandom), ($urandom % 2) ? 8'h0A : 8'h06,
            8'($urandom), 8'($urandom), int'($urandom % 8), int'($urandom % 8),
            ($urandom % 6) == 0, ($urandom % 3) == 0, ($urandom % 2) == 1);
      run("R3 random");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule